// File: doc/BRIEF.md
# NAND Chunk Hamming Parity Generator

This block sits on the byte data path between a host and a NAND flash device. Every byte that crosses the data port, whether the host writes it toward the flash or reads it from the flash, can be folded into a Hamming-style parity code. One code covers a 256-byte chunk. The code is 3 bytes long: 16 line-parity bits and 6 column-parity bits. The host later uses the code to locate and correct a single-bit error; correction itself is not part of this block.

Software steers the generator through a 2-bit mode field that travels with the data port. To start a chunk it selects clear, then off, then accumulate, and then moves the chunk. To collect the result it selects off, then readout, reads the data port three times, and returns to off. While readout is selected, reads of the data port return code bytes instead of flash data.

Top module: `nand_ecc_engine`

## Requirements
- R1: Mode value 2'b11 (clear) sets all parity accumulators and the byte index to zero at the next clock edge. A cleared or freshly reset code reads back as byte1=0x00, byte0=0x00, byte2=0x03.
- R2: Mode value 2'b01 (accumulate) folds each cycle with `xfer_valid`=1 into the code. The byte used is `flash_rdata` when `xfer_dir`=1 (host read) and `host_wdata` when `xfer_dir`=0 (host write).
- R3: Line parity: for each index bit k (0..7), one bit holds the XOR of the bit-parities of all accumulated bytes whose index has bit k at 0, and its partner the same for index bit k at 1. For k=0..3 these sit in code byte0 at bit 2k (index bit 0) and bit 2k+1 (index bit 1). For k=4..7 they sit in code byte1 at bits 2(k-4) and 2(k-4)+1.
- R4: Column parity: let C be the XOR of all accumulated bytes. For j=0..2, code byte2 bit 2+2j is the XOR of the bits of C whose position has bit j at 0, and bit 3+2j the XOR of those whose position has bit j at 1. Byte2 bits 1:0 are always 1.
- R5: The byte index starts at 0, advances by one for each accumulated byte, and wraps from 255 to 0, so byte 256 is folded in as index 0.
- R6: Mode value 2'b00 (off) freezes the code and the index; transfers in off mode change nothing.
- R7: In mode 2'b10 (readout), successive host reads return code byte1, then byte0, then byte2. Every further read returns 0xFF.
- R8: The readout sequence restarts at byte1 each time readout mode is entered, including when the first read happens in the entry cycle. Readout leaves the code intact, so a second fetch returns the same bytes.
- R9: Outside readout mode, `host_rdata` equals `flash_rdata`.
- R10: Transfers in readout mode, reads or writes, are not folded into the code and do not advance the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_mode | input | 2 | Parity mode: 00 off, 01 accumulate, 10 readout, 11 clear |
| xfer_valid | input | 1 | A byte crosses the data port in this cycle |
| xfer_dir | input | 1 | 1 = host read from flash, 0 = host write to flash |
| host_wdata | input | 8 | Byte written by the host |
| flash_rdata | input | 8 | Byte driven by the flash device |
| host_rdata | output | 8 | Byte returned to the host: flash data or a code byte |

## Verification
A wrong index bit shows up only in the line-parity bits that bit selects, and only at the next fetch. The bench therefore compares the full three-byte code after every chunk, including partial chunks and chunks longer than 256 bytes. A stale readout pointer shows on the very first read after readout is entered, as a wrong byte or an early 0xFF. A leak of off-mode or readout-mode traffic into the accumulators shows as a code mismatch on the next fetch.

// File: rtl/nand_ecc_pkg.sv
// Package: shared mode encoding and column-parity derivation for the
// NAND chunk parity generator. Assumes a byte-wide data port.
package nand_ecc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ECC_OFF     = 2'b00,
        ECC_ACCUM   = 2'b01,
        ECC_READOUT = 2'b10,
        ECC_CLEAR   = 2'b11
    } ecc_mode_e;

    // Derive the six column-parity bits {cp5..cp0} from the running XOR of bytes.
    function automatic logic [5:0] col_parity(input logic [BYTE_W-1:0] c);
        logic [5:0] r;
        r[0] = c[6] ^ c[4] ^ c[2] ^ c[0];
        r[1] = c[7] ^ c[5] ^ c[3] ^ c[1];
        r[2] = c[5] ^ c[4] ^ c[1] ^ c[0];
        r[3] = c[7] ^ c[6] ^ c[3] ^ c[2];
        r[4] = c[3] ^ c[2] ^ c[1] ^ c[0];
        r[5] = c[7] ^ c[6] ^ c[5] ^ c[4];
        return r;
    endfunction

endpackage

// File: rtl/ecc_mode_ctl.sv
// Module: ecc_mode_ctl
// Decodes the 2-bit parity mode and the transfer strobe into one-cycle
// actions for the accumulators and the readout sequencer. Remembers the
// previous mode so that entry into readout can be seen.
// Assumes ecc_mode is a level held by software between transfers.
module ecc_mode_ctl
    import nand_ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ecc_mode,
    input  logic       xfer_valid,
    input  logic       xfer_dir,
    output logic       acc_en,
    output logic       clr,
    output logic       ro_active,
    output logic       ro_enter,
    output logic       ro_read
);

    ecc_mode_e mode;
    ecc_mode_e mode_q;

    // Interpret the raw field as a mode value.
    always_comb mode = ecc_mode_e'(ecc_mode);

    // Remember the previous cycle's mode for readout entry detection.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= ECC_OFF;
        else        mode_q <= mode;
    end

    // Turn mode and strobe into the per-cycle actions.
    always_comb begin
        acc_en    = (mode == ECC_ACCUM) && xfer_valid;
        clr       = (mode == ECC_CLEAR);
        ro_active = (mode == ECC_READOUT);
        ro_enter  = ro_active && (mode_q != ECC_READOUT);
        ro_read   = ro_active && xfer_valid && xfer_dir;
    end

    AST_ENTER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ro_enter |=> !ro_enter); // R8

endmodule

// File: rtl/ecc_line_par.sv
// Module: ecc_line_par
// Holds the byte index counter and the line-parity accumulator pairs.
// For each index bit there is an "index bit 0" and an "index bit 1"
// accumulator; each collects the bit-parity of bytes whose index selects it.
// Assumes clear has priority and that the index wraps at 2**IDX_W.
module ecc_line_par #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8,
    localparam int LP_W  = 2 * IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_en,
    input  logic [DATA_W-1:0] data,
    output logic [LP_W-1:0]   lp,
    output logic [IDX_W-1:0]  idx
);

    logic [IDX_W-1:0] idx_q;
    logic             byte_par;

    // Parity of the byte being folded in.
    always_comb byte_par = ^data;

    // Advance the byte index on each accumulated byte, zero it on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (clr)    idx_q <= '0;
        else if (acc_en) idx_q <= idx_q + 1'b1;
    end

    for (genvar k = 0; k < IDX_W; k++) begin : g_lp
        logic lo_q;
        logic hi_q;

        // Fold the byte parity into the accumulator picked by index bit k.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lo_q <= 1'b0;
                hi_q <= 1'b0;
            end else if (acc_en) begin
                if (idx_q[k]) hi_q <= hi_q ^ byte_par;
                else          lo_q <= lo_q ^ byte_par;
            end
        end

        assign lp[2*k]     = lo_q;
        assign lp[2*k + 1] = hi_q;
    end

    assign idx = idx_q;

    AST_LP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lp == '0) && (idx == '0)); // R1
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !clr) |=> idx == IDX_W'($past(idx) + 1'b1)); // R5
    AST_LP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !clr) |=> $stable(lp) && $stable(idx)); // R6
    AST_LP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !clr) |=> $countones(lp ^ $past(lp)) == ($past(byte_par) ? IDX_W : 0)); // R3

endmodule

// File: rtl/ecc_col_par.sv
// Module: ecc_col_par
// Keeps the running XOR of all accumulated bytes and derives the six
// column-parity bits from it. Assumes a byte-wide data path.
module ecc_col_par
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_en,
    input  logic [BYTE_W-1:0] data,
    output logic [5:0]        cp
);

    logic [BYTE_W-1:0] col_q;

    // Running XOR of every accumulated byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) col_q <= '0;
        else if (acc_en)   col_q <= col_q ^ data;
    end

    // Column parity bits from the running XOR.
    always_comb cp = col_parity(col_q);

    AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cp == 6'd0)); // R1
    AST_COL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !clr) |=> $stable(cp)); // R6

endmodule

// File: rtl/ecc_readout.sv
// Module: ecc_readout
// Sequences the three code bytes onto the read port in the order
// byte1, byte0, byte2, then 0xFF. The pointer restarts on readout entry;
// a read in the entry cycle returns byte1. Assumes ro_read implies readout.
module ecc_readout
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ro_enter,
    input  logic              ro_read,
    input  logic [BYTE_W-1:0] code0,
    input  logic [BYTE_W-1:0] code1,
    input  logic [BYTE_W-1:0] code2,
    output logic [BYTE_W-1:0] ro_byte
);

    logic [1:0] ptr_q;
    logic [1:0] ptr_eff;

    // Entry overrides the stored pointer in the same cycle.
    always_comb ptr_eff = ro_enter ? 2'd0 : ptr_q;

    // Step the pointer per read, saturating at the filler slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ptr_q <= 2'd0;
        else if (ro_read && ptr_eff != 2'd3)  ptr_q <= ptr_eff + 2'd1;
        else if (ro_enter)                    ptr_q <= 2'd0;
    end

    // Pick the code byte for the current slot.
    always_comb begin
        case (ptr_eff)
            2'd0:    ro_byte = code1;
            2'd1:    ro_byte = code0;
            2'd2:    ro_byte = code2;
            default: ro_byte = 8'hFF;
        endcase
    end

    AST_ENTRY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_enter && !ro_read) |=> ptr_q == 2'd0); // R8
    AST_ENTRY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_enter && ro_read) |=> ptr_q == 2'd1); // R8
    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == 2'd3 && !ro_enter) |=> ptr_q == 2'd3); // R7

endmodule

// File: rtl/nand_ecc_engine.sv
// Module: nand_ecc_engine (top)
// Parity generator on the NAND byte data path. Selects the byte that
// crosses the port, folds it into line and column parity under mode
// control, and substitutes code bytes for flash data in readout mode.
// Assumes CHUNK_BYTES = 256 so the line parity fills exactly two bytes.
module nand_ecc_engine
    import nand_ecc_pkg::*;
#(
    parameter int CHUNK_BYTES = 256,
    localparam int IDX_W      = $clog2(CHUNK_BYTES),
    localparam int LP_W       = 2 * IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ecc_mode,
    input  logic              xfer_valid,
    input  logic              xfer_dir,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic [BYTE_W-1:0] flash_rdata,
    output logic [BYTE_W-1:0] host_rdata
);

    logic              acc_en, clr, ro_active, ro_enter, ro_read;
    logic [BYTE_W-1:0] port_byte;
    logic [LP_W-1:0]   lp;
    logic [IDX_W-1:0]  idx;
    logic [5:0]        cp;
    logic [BYTE_W-1:0] code0, code1, code2, ro_byte;

    // Byte on the port in the direction of the transfer.
    always_comb port_byte = xfer_dir ? flash_rdata : host_wdata;

    ecc_mode_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ecc_mode   (ecc_mode),
        .xfer_valid (xfer_valid),
        .xfer_dir   (xfer_dir),
        .acc_en     (acc_en),
        .clr        (clr),
        .ro_active  (ro_active),
        .ro_enter   (ro_enter),
        .ro_read    (ro_read)
    );

    ecc_line_par #(.IDX_W(IDX_W), .DATA_W(BYTE_W)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .acc_en (acc_en),
        .data   (port_byte),
        .lp     (lp),
        .idx    (idx)
    );

    ecc_col_par u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .acc_en (acc_en),
        .data   (port_byte),
        .cp     (cp)
    );

    // Pack the three code bytes: line parity low/high, then column parity.
    always_comb begin
        code0 = lp[BYTE_W-1:0];
        code1 = lp[LP_W-1:BYTE_W];
        code2 = {cp, 2'b11};
    end

    ecc_readout u_ro (
        .clk      (clk),
        .rst_n    (rst_n),
        .ro_enter (ro_enter),
        .ro_read  (ro_read),
        .code0    (code0),
        .code1    (code1),
        .code2    (code2),
        .ro_byte  (ro_byte)
    );

    // Code bytes replace flash data only while readout is selected.
    always_comb host_rdata = ro_active ? ro_byte : flash_rdata;

    AST_RO_NO_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
        ro_active |=> $stable(idx) && $stable(code0) && $stable(code1)); // R10

endmodule

// File: tb/sim_nand_ecc_engine.sv
module sim_nand_ecc_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ecc_mode = 2'b00;
    logic       xfer_valid = 1'b0;
    logic       xfer_dir = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] flash_rdata = 8'h00;
    logic [7:0] host_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Bench model of the code state
    logic [7:0] m_lo, m_hi, m_col, m_idx;
    logic [1:0] cur_mode = 2'b00;

    always #2 clk = ~clk;

    nand_ecc_engine u0 (
        .clk(clk), .rst_n(rst_n), .ecc_mode(ecc_mode), .xfer_valid(xfer_valid),
        .xfer_dir(xfer_dir), .host_wdata(host_wdata), .flash_rdata(flash_rdata),
        .host_rdata(host_rdata)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_lo = 0; m_hi = 0; m_col = 0; m_idx = 0;
    endtask

    task automatic model_byte(input logic [7:0] b);
        logic p;
        p = ^b;
        for (int k = 0; k < 8; k++) begin
            if (m_idx[k]) m_hi[k] = m_hi[k] ^ p;
            else          m_lo[k] = m_lo[k] ^ p;
        end
        m_col = m_col ^ b;
        m_idx = m_idx + 8'd1;
    endtask

    // Expected code byte n (0,1,2) from the model, per R3 and R4
    function automatic logic [7:0] exp_code(input int n);
        logic [7:0] r;
        r = 8'h00;
        if (n == 0 || n == 1) begin
            for (int k = 0; k < 4; k++) begin
                r[2*k]     = m_lo[4*n + k];
                r[2*k + 1] = m_hi[4*n + k];
            end
        end else begin
            r[1:0] = 2'b11;
            for (int j = 0; j < 3; j++) begin
                logic a0, a1;
                a0 = 0; a1 = 0;
                for (int b = 0; b < 8; b++) begin
                    if (b[j]) a1 = a1 ^ m_col[b];
                    else      a0 = a0 ^ m_col[b];
                end
                r[2 + 2*j] = a0;
                r[3 + 2*j] = a1;
            end
        end
        return r;
    endfunction

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        ecc_mode = m; xfer_valid = 1'b0;
        cur_mode = m;
        if (m == 2'b11) model_clear();
        @(posedge clk);
    endtask

    // One byte across the port in the current mode
    task automatic xfer(input logic dir, input logic [7:0] b, input bit chk_pass);
        @(negedge clk);
        xfer_valid = 1'b1; xfer_dir = dir;
        if (dir) flash_rdata = b; else host_wdata = b;
        if (!dir) flash_rdata = 8'($urandom);
        #1;
        if (chk_pass && cur_mode != 2'b10) chk(host_rdata, flash_rdata, "R9 passthrough");
        @(posedge clk);
        if (cur_mode == 2'b01) model_byte(b);
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic ro_rd(input logic [7:0] exp, input string req);
        @(negedge clk);
        xfer_valid = 1'b1; xfer_dir = 1'b1; flash_rdata = 8'($urandom);
        #1;
        chk(host_rdata, exp, req);
        @(posedge clk);
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic fetch(input string req);
        set_mode(2'b00);
        set_mode(2'b10);
        ro_rd(exp_code(1), {req, " byte1"});
        ro_rd(exp_code(0), {req, " byte0"});
        ro_rd(exp_code(2), {req, " byte2"});
        set_mode(2'b00);
    endtask

    task automatic prep();
        set_mode(2'b11);
        set_mode(2'b00);
        set_mode(2'b01);
    endtask

    task automatic run_chunk(input int len, input int dirsel);
        for (int i = 0; i < len; i++) begin
            logic d;
            d = (dirsel == 2) ? 1'($urandom) : 1'(dirsel);
            xfer(d, 8'($urandom), (i % 64) == 0);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // Reset state: off mode passthrough and empty code (R1, R9)
        xfer(1'b1, 8'hA5, 1'b1);
        fetch("R1 reset code");

        // Directed single byte 0x01 at index 0 (R3, R4)
        prep();
        xfer(1'b0, 8'h01, 1'b0);
        set_mode(2'b00);
        set_mode(2'b10);
        ro_rd(8'h55, "R3 single byte1");
        ro_rd(8'h55, "R3 single byte0");
        ro_rd(8'h57, "R4 single byte2");
        set_mode(2'b00);

        // Full chunks: writes, reads, mixed directions (R2, R3, R4)
        prep(); run_chunk(256, 0); fetch("R2 write chunk");
        prep(); run_chunk(256, 1); fetch("R2 read chunk");
        for (int t = 0; t < 4; t++) begin
            prep(); run_chunk(1 + int'($urandom % 256), 2); fetch("R3 random partial chunk");
        end

        // Wrap beyond 256 bytes (R5)
        prep(); run_chunk(300, 2); fetch("R5 wrapped index");

        // Off freezes, then accumulation resumes at the same index (R6)
        prep(); run_chunk(50, 2);
        set_mode(2'b00); run_chunk(20, 2);
        fetch("R6 off freeze");
        set_mode(2'b01); run_chunk(30, 2);
        fetch("R6 resume after off");

        // Extra reads return 0xFF, re-entry restarts and code is intact (R7, R8)
        set_mode(2'b10);
        ro_rd(exp_code(1), "R7 order byte1");
        ro_rd(exp_code(0), "R7 order byte0");
        ro_rd(exp_code(2), "R7 order byte2");
        ro_rd(8'hFF, "R7 fourth read");
        ro_rd(8'hFF, "R7 fifth read");
        set_mode(2'b00);
        fetch("R8 refetch");

        // Read in the entry cycle returns byte1 (R8)
        @(negedge clk);
        ecc_mode = 2'b10; cur_mode = 2'b10;
        xfer_valid = 1'b1; xfer_dir = 1'b1;
        #1 chk(host_rdata, exp_code(1), "R8 entry-cycle read");
        @(posedge clk);
        @(negedge clk) xfer_valid = 1'b0;
        ro_rd(exp_code(0), "R8 after entry read");

        // Writes and reads during readout do not accumulate (R10)
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            xfer_valid = 1'b1; xfer_dir = 1'b0; host_wdata = 8'($urandom);
            @(posedge clk);
        end
        @(negedge clk) xfer_valid = 1'b0;
        set_mode(2'b00);
        fetch("R10 readout traffic ignored");
        set_mode(2'b01); xfer(1'b0, 8'h80, 1'b0);
        fetch("R10 index unchanged by readout");

        // Clear after data empties the code (R1)
        set_mode(2'b11); set_mode(2'b00);
        fetch("R1 clear");

        done = 1'b1;
        finish_up();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

endmodule